// File: doc/BRIEF.md
# Security-Filtered Shared Interrupt State Bank

This block keeps the enable, pending and active state of a set of shared interrupts (IDs 32 and up) and exposes it through 32-bit register windows. Each kind of state is reached through two windows: a set window, where a 1 bit sets the state bit, and a clear window, where a 1 bit clears it. A 0 bit changes nothing. Every access carries a secure attribute. A non-secure access, when the bank is not in single-security-state mode, only reaches the bits that a per-interrupt permission mask allows. The mask is built from the interrupt's group bit and its 2-bit access level, and the level it takes depends on the window being accessed.

The bank also samples the interrupt input lines each clock. A rising line on an interrupt configured as edge-triggered latches its pending bit. For level-triggered interrupts, a pending read reports the latched bit ORed with the sampled line level. Group bits, access levels, trigger modes and the single-security-state flag come in as configuration vectors from neighbouring logic. Read data is registered.

Top module: `spi_secure_bitmap_regs`

## Requirements
- R1: Address decode. `addr_i[9:7]` selects the window: 0 = enable set, 1 = enable clear, 2 = pending set, 3 = pending clear, 4 = active set, 5 = active clear. Windows 6 and 7 read as zero and ignore writes. `addr_i[6:2]` is the word index w. Bit b of word w is interrupt ID 32*w+b. An access with `addr_i[1:0]` non-zero reads as zero and is ignored.
- R2: Word 0 (the internal IDs 0..31) and every word at or above the implemented count (w >= 3 with 64 interrupts) read as zero and ignore writes.
- R3: In a set window a written 1 sets the permitted state bit and a 0 leaves it alone. In a clear window a written 1 clears it. Both windows of one kind read the same state.
- R4: Filtering applies only when `secure_i`=0 and `single_sec_i`=0. Otherwise every bit is accessible.
- R5: Under filtering, an enable-window bit is accessible only if the interrupt's group bit (`group_i[ID-32]`) is 1.
- R6: Under filtering, a pending-set bit is accessible for read and write if the group bit is 1 or the access level (`acc_i[2*(ID-32)+1 : 2*(ID-32)]`) is 1 or more.
- R7: Under filtering, pending-clear reads and writes, and reads of both active windows, need the group bit to be 1 or the upper access-level bit to be 1 (level 2 or more).
- R8: Under filtering, writes to the active windows need the group bit to be 1. The access level does not grant them.
- R9: A bit that is not accessible reads as 0, and writes to it leave the state unchanged.
- R10: A read of either pending window returns latched pending ORed with (sampled line level AND NOT edge-triggered), before the mask is applied.
- R11: The line inputs are sampled each clock. A 0-to-1 change on a line whose `edge_cfg_i` bit is 1 sets that pending bit at that same clock edge. A level-triggered line, or a line that does not change, never latches pending.
- R12: When an edge latch and a pending-clear write hit the same bit in the same cycle, the bit ends up set.
- R13: `rdata_o` carries the read result in the cycle after `rd_en_i` and is zero in any cycle that follows a cycle without a read. All state and `rdata_o` reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 10 | Byte address: window, word index, byte lane |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Access is secure |
| single_sec_i | input | 1 | Single security state; disables filtering |
| group_i | input | 64 | Group bit per interrupt |
| acc_i | input | 128 | 2-bit non-secure access level per interrupt |
| edge_cfg_i | input | 64 | 1 = edge-triggered interrupt |
| irq_i | input | 64 | Interrupt input lines |
| rdata_o | output | 32 | Registered read data |
| enable_o | output | 64 | Enable state |
| pending_o | output | 64 | Latched pending state |
| active_o | output | 64 | Active state |

## Verification
A write changes `enable_o`, `pending_o` and `active_o` at the clock edge that captures it. The bench compares these outputs at the falling edge that follows that edge. A read result shows on `rdata_o` at the edge after the strobe, so the bench samples it half a cycle later, before the next edge replaces it. A line change is taken at the next rising edge. That edge updates both the edge latch and the level seen by pending reads, so the bench updates its model at that edge and checks `pending_o` at the falling edge after it.

// File: rtl/spi_sec_pkg.sv
// Shared constants and window encoding for the secure-filtered interrupt
// state bank. Assumes 32-bit register words.
package spi_sec_pkg;
    localparam int unsigned WORD_BITS = 32;

    // Window selector taken from the upper address bits.
    typedef enum logic [2:0] {
        WIN_EN_SET = 3'd0,
        WIN_EN_CLR = 3'd1,
        WIN_PD_SET = 3'd2,
        WIN_PD_CLR = 3'd3,
        WIN_AC_SET = 3'd4,
        WIN_AC_CLR = 3'd5,
        WIN_RSV_6  = 3'd6,
        WIN_RSV_7  = 3'd7
    } win_e;
endpackage

// File: rtl/spi_perm_mask.sv
// Builds three per-interrupt permission masks: group only, group or
// level >= 1, and group or level >= 2. Every mask is all ones unless the
// access is non-secure and the bank runs with two security states.
// Purely combinational.
module spi_perm_mask #(
    parameter int unsigned N_SPI = 64
) (
    input  logic                 secure_i,
    input  logic                 single_sec_i,
    input  logic [N_SPI-1:0]     group_i,
    input  logic [2*N_SPI-1:0]   acc_i,
    output logic [N_SPI-1:0]     m_grp_o,
    output logic [N_SPI-1:0]     m_ge1_o,
    output logic [N_SPI-1:0]     m_ge2_o
);
    logic filt;

    // Filtering is active only for non-secure accesses with two states.
    assign filt = !secure_i && !single_sec_i;

    for (genvar i = 0; i < N_SPI; i++) begin : g_bit
        // Each bit: open when unfiltered, else by group bit or level threshold.
        assign m_grp_o[i] = !filt || group_i[i];
        assign m_ge1_o[i] = !filt || group_i[i] || acc_i[2*i] || acc_i[2*i+1];
        assign m_ge2_o[i] = !filt || group_i[i] || acc_i[2*i+1];
    end
endmodule

// File: rtl/spi_line_sampler.sv
// Registers the interrupt input lines once per clock and flags a rising
// transition on lines configured as edge-triggered. Assumes the lines are
// already synchronous to clk.
module spi_line_sampler #(
    parameter int unsigned N_SPI = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SPI-1:0] line_i,
    input  logic [N_SPI-1:0] edge_cfg_i,
    output logic [N_SPI-1:0] level_o,
    output logic [N_SPI-1:0] rise_o
);
    logic [N_SPI-1:0] lvl_q;

    // Keep the previous sampled level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= line_i;
    end

    assign level_o = lvl_q;
    assign rise_o  = line_i & ~lvl_q & edge_cfg_i;
endmodule

// File: rtl/spi_state_bank.sv
// One vector of per-interrupt state bits with bitwise clear and set inputs.
// Set wins over clear, so a hardware set is never lost to a concurrent clear.
module spi_state_bank #(
    parameter int unsigned N_SPI = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SPI-1:0] set_i,
    input  logic [N_SPI-1:0] clr_i,
    input  logic [N_SPI-1:0] hw_set_i,
    output logic [N_SPI-1:0] state_o
);
    logic [N_SPI-1:0] state_q;

    // Apply clears first, then software and hardware sets.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= (state_q & ~clr_i) | set_i | hw_set_i;
    end

    assign state_o = state_q;
endmodule

// File: rtl/spi_secure_bitmap_regs.sv
// Top of the security-filtered shared interrupt state bank. Decodes the
// window and word from the byte address and filters write data and read
// data through the permission mask for that window. Drives three state
// banks and registers the read result. Assumes N_SPI is a multiple of 32,
// that IDs start at 32, and that ADDR_W leaves 5 word-index bits.
module spi_secure_bitmap_regs
    import spi_sec_pkg::*;
#(
    parameter int unsigned N_SPI  = 64,
    parameter int unsigned ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_BITS-1:0] wdata_i,
    input  logic                 secure_i,
    input  logic                 single_sec_i,
    input  logic [N_SPI-1:0]     group_i,
    input  logic [2*N_SPI-1:0]   acc_i,
    input  logic [N_SPI-1:0]     edge_cfg_i,
    input  logic [N_SPI-1:0]     irq_i,
    output logic [WORD_BITS-1:0] rdata_o,
    output logic [N_SPI-1:0]     enable_o,
    output logic [N_SPI-1:0]     pending_o,
    output logic [N_SPI-1:0]     active_o
);
    localparam int unsigned N_WORDS = N_SPI / WORD_BITS;
    localparam int unsigned WIN_LSB = ADDR_W - 3;
    localparam int unsigned IDX_W   = WIN_LSB - 2;

    win_e                 win;
    logic [IDX_W-1:0]     widx;
    logic                 aligned;
    logic [N_WORDS-1:0]   word_hit;
    logic [N_SPI-1:0]     m_grp, m_ge1, m_ge2;
    logic [N_SPI-1:0]     line_lvl, line_rise;
    logic [N_SPI-1:0]     en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
    logic [N_SPI-1:0]     pend_view;
    logic [WORD_BITS-1:0] rd_val;
    logic [WORD_BITS-1:0] rdata_q;

    assign win     = win_e'(addr_i[ADDR_W-1:WIN_LSB]);
    assign widx    = addr_i[WIN_LSB-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);

    spi_perm_mask #(.N_SPI(N_SPI)) u_mask (
        .secure_i     (secure_i),
        .single_sec_i (single_sec_i),
        .group_i      (group_i),
        .acc_i        (acc_i),
        .m_grp_o      (m_grp),
        .m_ge1_o      (m_ge1),
        .m_ge2_o      (m_ge2)
    );

    spi_line_sampler #(.N_SPI(N_SPI)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (irq_i),
        .edge_cfg_i (edge_cfg_i),
        .level_o    (line_lvl),
        .rise_o     (line_rise)
    );

    // Per implemented word: decode the hit and steer masked write data.
    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        localparam int unsigned LO = k * WORD_BITS;
        logic [WORD_BITS-1:0] wd;

        assign word_hit[k] = aligned && (widx == IDX_W'(k + 1));
        assign wd = (wr_en_i && word_hit[k]) ? wdata_i : '0;

        assign en_set[LO +: WORD_BITS] = (win == WIN_EN_SET) ? (wd & m_grp[LO +: WORD_BITS]) : '0;
        assign en_clr[LO +: WORD_BITS] = (win == WIN_EN_CLR) ? (wd & m_grp[LO +: WORD_BITS]) : '0;
        assign pd_set[LO +: WORD_BITS] = (win == WIN_PD_SET) ? (wd & m_ge1[LO +: WORD_BITS]) : '0;
        assign pd_clr[LO +: WORD_BITS] = (win == WIN_PD_CLR) ? (wd & m_ge2[LO +: WORD_BITS]) : '0;
        assign ac_set[LO +: WORD_BITS] = (win == WIN_AC_SET) ? (wd & m_grp[LO +: WORD_BITS]) : '0;
        assign ac_clr[LO +: WORD_BITS] = (win == WIN_AC_CLR) ? (wd & m_grp[LO +: WORD_BITS]) : '0;
    end

    spi_state_bank #(.N_SPI(N_SPI)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (en_set),
        .clr_i    (en_clr),
        .hw_set_i ('0),
        .state_o  (enable_o)
    );

    spi_state_bank #(.N_SPI(N_SPI)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (pd_set),
        .clr_i    (pd_clr),
        .hw_set_i (line_rise),
        .state_o  (pending_o)
    );

    spi_state_bank #(.N_SPI(N_SPI)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ac_set),
        .clr_i    (ac_clr),
        .hw_set_i ('0),
        .state_o  (active_o)
    );

    // Pending as seen by reads: latch merged with level-triggered line level.
    assign pend_view = pending_o | (line_lvl & ~edge_cfg_i);

    // Select and mask the addressed word for a read.
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (word_hit[k]) begin
                case (win)
                    WIN_EN_SET, WIN_EN_CLR:
                        rd_val = enable_o[k*WORD_BITS +: WORD_BITS] & m_grp[k*WORD_BITS +: WORD_BITS];
                    WIN_PD_SET:
                        rd_val = pend_view[k*WORD_BITS +: WORD_BITS] & m_ge1[k*WORD_BITS +: WORD_BITS];
                    WIN_PD_CLR:
                        rd_val = pend_view[k*WORD_BITS +: WORD_BITS] & m_ge2[k*WORD_BITS +: WORD_BITS];
                    WIN_AC_SET, WIN_AC_CLR:
                        rd_val = active_o[k*WORD_BITS +: WORD_BITS] & m_ge2[k*WORD_BITS +: WORD_BITS];
                    default:
                        rd_val = '0;
                endcase
            end
        end
    end

    // Register read data; zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_val;
        else              rdata_q <= '0;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/spi_secure_bitmap_regs_chk.sv
// Property checker for the secure-filtered interrupt state bank, attached
// to every instance of the top through bind. Observes ports and the
// sampled line level only.
module spi_secure_bitmap_regs_chk #(
    parameter int unsigned N_SPI  = 64,
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [N_SPI-1:0]  edge_cfg_i,
    input logic [N_SPI-1:0]  irq_i,
    input logic [31:0]       rdata_o,
    input logic [N_SPI-1:0]  enable_o,
    input logic [N_SPI-1:0]  pending_o,
    input logic [N_SPI-1:0]  active_o,
    input logic [N_SPI-1:0]  line_lvl
);
    logic [2:0]        win_f;
    logic [ADDR_W-6:0] word_f;
    logic [N_SPI-1:0]  rise_seen;

    assign win_f     = addr_i[ADDR_W-1 -: 3];
    assign word_f    = addr_i[ADDR_W-4:2];
    assign rise_seen = irq_i & ~line_lvl & edge_cfg_i;

    assert_idle_rdata_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rdata_o == '0));

    assert_reserved_window_raz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && win_f >= 3'd6) |=> (rdata_o == '0));

    assert_internal_word_raz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && word_f == '0) |=> (rdata_o == '0));

    assert_internal_word_wi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && word_f == '0) |=> ($stable(enable_o) && $stable(active_o)));

    assert_set_never_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && win_f == 3'd0) |=> ((enable_o & $past(enable_o)) == $past(enable_o)));

    assert_clear_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && win_f == 3'd1) |=> ((enable_o & ~$past(enable_o)) == '0));

    // Also covers R12: the latch holds even against a same-cycle clear write.
    assert_edge_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_seen) |=> ((pending_o & $past(rise_seen)) == $past(rise_seen)));

    assert_level_never_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((pending_o & ~$past(pending_o) & ~$past(edge_cfg_i)) == '0));
endmodule

bind spi_secure_bitmap_regs spi_secure_bitmap_regs_chk #(
    .N_SPI  (N_SPI),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/sim_spi_secure_bitmap_regs.sv
`timescale 1ns/1ps
module sim_spi_secure_bitmap_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [9:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic         sec = 1'b1, ss = 1'b0;
    logic [63:0]  grp = '0, edg = '0, irq = '0;
    logic [127:0] acc = '0;
    logic [31:0]  rdata;
    logic [63:0]  enable_o, pending_o, active_o;

    logic [63:0]  en_m = '0, pd_m = '0, ac_m = '0, lvl_m = '0;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    spi_secure_bitmap_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .secure_i(sec), .single_sec_i(ss),
        .group_i(grp), .acc_i(acc), .edge_cfg_i(edg), .irq_i(irq),
        .rdata_o(rdata), .enable_o(enable_o), .pending_o(pending_o),
        .active_o(active_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // thr: 0 group only, 1 level>=1, 2 level>=2 (R4..R8)
    function automatic logic [31:0] perm(input int thr, input int w);
        logic [31:0] m;
        for (int b = 0; b < 32; b++) begin
            case (thr)
                0:       m[b] = grp[(w-1)*32+b];
                1:       m[b] = grp[(w-1)*32+b] | acc[2*((w-1)*32+b)] | acc[2*((w-1)*32+b)+1];
                default: m[b] = grp[(w-1)*32+b] | acc[2*((w-1)*32+b)+1];
            endcase
        end
        if (sec || ss) m = '1;
        return m;
    endfunction

    function automatic logic [31:0] exp_read(input int win, input int w);
        logic [63:0] pv;
        pv = pd_m | (lvl_m & ~edg);
        if (w < 1 || w > 2 || win > 5) return '0;
        case (win)
            0, 1:    return en_m[(w-1)*32 +: 32] & perm(0, w);
            2:       return pv[(w-1)*32 +: 32] & perm(1, w);
            3:       return pv[(w-1)*32 +: 32] & perm(2, w);
            default: return ac_m[(w-1)*32 +: 32] & perm(2, w);
        endcase
    endfunction

    task automatic model_write(input int win, input int w, input logic [31:0] d);
        if (w < 1 || w > 2 || win > 5) return;
        case (win)
            0: en_m[(w-1)*32 +: 32] = en_m[(w-1)*32 +: 32] | (d & perm(0, w));
            1: en_m[(w-1)*32 +: 32] = en_m[(w-1)*32 +: 32] & ~(d & perm(0, w));
            2: pd_m[(w-1)*32 +: 32] = pd_m[(w-1)*32 +: 32] | (d & perm(1, w));
            3: pd_m[(w-1)*32 +: 32] = pd_m[(w-1)*32 +: 32] & ~(d & perm(2, w));
            4: ac_m[(w-1)*32 +: 32] = ac_m[(w-1)*32 +: 32] | (d & perm(0, w));
            default: ac_m[(w-1)*32 +: 32] = ac_m[(w-1)*32 +: 32] & ~(d & perm(0, w));
        endcase
    endtask

    task automatic compare_state(input string tag);
        check({tag, " enable"},  enable_o,  en_m);
        check({tag, " pending"}, pending_o, pd_m);
        check({tag, " active"},  active_o,  ac_m);
    endtask

    task automatic do_write(input int win, input int w, input logic [31:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = {3'(win), 5'(w), 2'b00}; wdata = d;
        @(posedge clk);
        model_write(win, w, d);
        @(negedge clk);
        wr_en = 1'b0;
        compare_state(tag);
    endtask

    task automatic do_read(input int win, input int w, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = {3'(win), 5'(w), 2'b00};
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, {32'h0, rdata}, {32'h0, exp_read(win, w)});
    endtask

    task automatic set_lines(input logic [63:0] v, input string tag);
        @(negedge clk);
        irq = v;
        @(posedge clk);
        pd_m  = pd_m | (v & ~lvl_m & edg);
        lvl_m = v;
        @(negedge clk);
        check(tag, pending_o, pd_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        compare_state("R13 reset");
        check("R13 reset rdata", {32'h0, rdata}, 64'h0);

        // R4: single security state opens all bits to a non-secure write
        sec = 1'b0; ss = 1'b1; grp = '0;
        do_write(0, 1, 32'hFFFF_FFFF, "R4 single-state enable set");
        do_read(1, 1, "R4 single-state read via clear window");
        ss = 1'b0;
        // R5 R9: filtered, group zero: enable clear is ignored, read is zero
        do_write(1, 1, 32'hFFFF_FFFF, "R5 filtered enable clear ignored");
        do_read(0, 1, "R9 filtered enable read zero");
        grp[3] = 1'b1;
        do_write(1, 1, 32'h0000_0008, "R5 group bit opens enable clear");

        // R6 R7: access level 1 on ID 32
        acc[1:0] = 2'd1;
        do_write(2, 1, 32'h0000_0001, "R6 level1 pending set");
        do_read(2, 1, "R6 level1 pending set window read");
        do_write(3, 1, 32'h0000_0001, "R7 level1 pending clear ignored");
        do_read(3, 1, "R7 level1 pending clear window reads zero");
        acc[1:0] = 2'd2;
        do_write(3, 1, 32'h0000_0001, "R7 level2 pending clear");
        // R8: level 3 still does not open active writes
        acc[1:0] = 2'd3;
        do_write(4, 1, 32'h0000_0001, "R8 active write needs group");
        sec = 1'b1;
        do_write(4, 1, 32'h0000_0001, "R8 secure active set");
        sec = 1'b0;
        do_read(5, 1, "R7 level3 active read");

        // R1 R2: reserved windows, internal and unimplemented words
        sec = 1'b1;
        do_write(6, 1, 32'hFFFF_FFFF, "R1 reserved window write ignored");
        do_read(7, 1, "R1 reserved window read zero");
        do_write(0, 0, 32'hFFFF_FFFF, "R2 internal word write ignored");
        do_read(0, 0, "R2 internal word read zero");
        do_write(4, 3, 32'hFFFF_FFFF, "R2 word beyond count ignored");
        do_read(0, 3, "R2 word beyond count read zero");
        @(negedge clk);
        wr_en = 1'b1; addr = {3'd0, 5'd2, 2'b01}; wdata = '1;
        @(negedge clk);
        wr_en = 1'b0;
        compare_state("R1 unaligned write ignored");

        // R10: level-triggered line merges into the pending read
        edg = '0;
        set_lines(64'h0000_0001_0000_0000, "R11 level line no latch");
        do_read(2, 2, "R10 level merged into pending read");
        set_lines(64'h0, "R11 level line drop");
        // R11 R12: edge latch beats a same-cycle clear write
        edg = 64'h0000_0002_0000_0000;
        @(negedge clk);
        irq = 64'h0000_0002_0000_0000;
        wr_en = 1'b1; addr = {3'd3, 5'd2, 2'b00}; wdata = 32'h0000_0002;
        @(posedge clk);
        model_write(3, 2, 32'h0000_0002);
        pd_m = pd_m | (irq & ~lvl_m & edg);
        lvl_m = irq;
        @(negedge clk);
        wr_en = 1'b0;
        check("R12 edge beats clear", pending_o, pd_m);
        set_lines(64'h0000_0002_0000_0000, "R11 steady line no action");

        // Random mix against the model
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 8);
            sec = 1'($urandom);
            if (op < 3) begin
                do_write(int'($urandom % 8), int'($urandom % 4), $urandom, "R3 random write");
            end else if (op < 6) begin
                do_read(int'($urandom % 8), int'($urandom % 4), "R9 random read");
            end else if (op == 6) begin
                set_lines({$urandom, $urandom}, "R11 random lines");
            end else begin
                @(negedge clk);
                grp = {$urandom, $urandom};
                acc = {$urandom, $urandom, $urandom, $urandom};
                edg = {$urandom, $urandom};
                ss  = (($urandom % 4) == 0);
            end
        end
        @(negedge clk);
        check("R13 idle rdata zero", {32'h0, rdata}, 64'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule